// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches a single 16-bit word from a serial EEPROM that uses three wires: a select line, a clock and a data line in each direction. The host presents a 6-bit word address and a one-cycle start strobe. The block then runs the read frame on its own. First it drives an external device-select bus to a code that routes the serial lines to the EEPROM. It then raises chip select and clocks out a four-bit command preamble and the address. Finally it clocks in sixteen data bits.

When the frame ends, the block parks the serial clock low with chip select still high, and then drops every serial line and the device-select bus to zero. It returns the received word with its two bytes exchanged and flags it with a one-cycle done pulse. The parameter `HALF_DIV` sets how many system-clock cycles each serial-clock half-period lasts, so the whole read takes a fixed `55*HALF_DIV` cycles from start to done.

Top module: `sprom_word_reader`

## Requirements
- R1: After reset, `cs_o`, `sclk_o`, `sdo_o`, `dev_sel_o`, `done_o` and `word_o` are all zero and the block is idle.
- R2: A start accepted while idle drives `dev_sel_o` to `SEL_CODE` from the next cycle. The code is held for one phase (`HALF_DIV` cycles) before `cs_o` rises, stays through the whole frame, and returns to zero in the cycle `done_o` is high.
- R3: `cs_o` is high from the setup phase up to and including the closing phase. `sclk_o` is only ever high while `cs_o` is high, and it is low in the phase before `cs_o` falls.
- R4: The first four serial bits sent are 0, 1, 1, 0, in that order.
- R5: The next six bits are the word address latched at start, most significant bit first.
- R6: Every serial bit has one low phase followed by one high phase, each `HALF_DIV` system cycles long. `sdo_o` is set during the low phase and does not change when `sclk_o` rises.
- R7: Sixteen data bits are taken from `sdi_i` on the last system cycle of each high phase of bits 10 to 25, most significant bit first.
- R8: `word_o` equals the received word with its bytes swapped: received bits 7..0 appear in `word_o[15:8]` and received bits 15..8 in `word_o[7:0]`. The value holds until the next read completes.
- R9: `done_o` is high for exactly one cycle, `55*HALF_DIV` cycles after the edge that accepted the start. In that cycle every serial line is zero.
- R10: A start strobe while a read is in progress is ignored: the frame in flight, its address and its timing are unchanged.
- R11: `sdo_o` is low during the sixteen data-bit periods and whenever `cs_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a read |
| addr_i | input | 6 | Word address, sampled with an accepted start |
| done_o | output | 1 | One-cycle pulse when `word_o` is valid |
| word_o | output | 16 | Byte-swapped result of the last read |
| dev_sel_o | output | SEL_W | External serial-device select bus |
| cs_o | output | 1 | EEPROM chip select, active high |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data toward the EEPROM |
| sdi_i | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the block with `HALF_DIV = 3`, `SEL_W = 3` and `SEL_CODE = 3'b101`. An odd divider makes the phase counter wrap at a value other than a power of two. It also leaves room for the EEPROM stub to change `sdi_i` half a system cycle after each serial-clock rise, well before the sampling cycle. If the block sampled in the low phase, it would therefore pick up the previous bit. The small divider keeps each frame at 165 cycles. That leaves room for reads at the address extremes, a start strobe in mid-frame, and a new start issued in the very cycle that `done_o` is high.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

  localparam int ADDR_W     = 6;
  localparam int WORD_W     = 16;
  localparam int PRE_W      = 4;
  localparam logic [PRE_W-1:0] PREAMBLE = 4'b0110;
  localparam int CMD_W      = PRE_W + ADDR_W;
  localparam int FRAME_BITS = CMD_W + WORD_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } seq_state_t;

  // Command bits in transmit order: preamble, then address MSB first.
  function automatic logic [CMD_W-1:0] cmd_frame(input logic [ADDR_W-1:0] a);
    return {PREAMBLE, a};
  endfunction

  // Level to drive on the data-out line for a given bit position of the frame.
  function automatic logic frame_bit(input logic [CMD_W-1:0] cmd,
                                     input logic [IDX_W-1:0] idx);
    int i;
    i = int'(idx);
    if (i < CMD_W) return cmd[CMD_W-1-i];
    return 1'b0;
  endfunction

  // Exchange upper and lower halves of the received word.
  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    return {w[WORD_W/2-1:0], w[WORD_W-1:WORD_W/2]};
  endfunction

endpackage

// File: rtl/sprom_phase_timer.sv
module sprom_phase_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sprom_seq.sv
module sprom_seq
  import sprom_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  output seq_state_t       state,
  output logic [IDX_W-1:0] bit_idx,
  output logic             accept,
  output logic             finish,
  output logic             sample_evt
);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] FIRST_RX  = IDX_W'(CMD_W);

  assign accept     = (state == ST_IDLE) && start;
  assign finish     = (state == ST_TAIL) && tick;
  assign sample_evt = (state == ST_HIGH) && tick && (bit_idx >= FIRST_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_SEL;
        ST_SEL:   if (tick)  state <= ST_SETUP;
        ST_SETUP: if (tick) begin
          state   <= ST_LOW;
          bit_idx <= '0;
        end
        ST_LOW:   if (tick)  state <= ST_HIGH;
        ST_HIGH:  if (tick) begin
          if (bit_idx == LAST_BIT) begin
            state <= ST_TAIL;
          end else begin
            state   <= ST_LOW;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_TAIL:  if (tick)  state <= ST_IDLE;
        default:             state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sprom_rx_shift.sv
module sprom_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/sprom_word_reader.sv
module sprom_word_reader
  import sprom_pkg::*;
#(
  parameter int               HALF_DIV = 4,
  parameter int               SEL_W    = 3,
  parameter logic [SEL_W-1:0] SEL_CODE = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic [SEL_W-1:0]  dev_sel_o,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  seq_state_t        state;
  logic [IDX_W-1:0]  bit_idx;
  logic              phase_tick;
  logic              accept;
  logic              finish;
  logic              sample_evt;
  logic              seq_run;
  logic              in_frame;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_bits;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] word_q;
  logic              done_q;

  assign seq_run = (state != ST_IDLE);

  sprom_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (seq_run),
    .tick (phase_tick)
  );

  sprom_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .tick      (phase_tick),
    .state     (state),
    .bit_idx   (bit_idx),
    .accept    (accept),
    .finish    (finish),
    .sample_evt(sample_evt)
  );

  sprom_rx_shift #(.W(WORD_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(sample_evt),
    .din     (sdi_i),
    .q       (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) word_q <= swap_bytes(rx_word);
    end
  end

  assign cmd_bits  = cmd_frame(addr_q);
  assign in_frame  = (state == ST_LOW) || (state == ST_HIGH);
  assign cs_o      = in_frame || (state == ST_SETUP) || (state == ST_TAIL);
  assign sclk_o    = (state == ST_HIGH);
  assign sdo_o     = in_frame && frame_bit(cmd_bits, bit_idx);
  assign dev_sel_o = seq_run ? SEL_CODE : '0;
  assign done_o    = done_q;
  assign word_o    = word_q;
endmodule

// File: rtl/sprom_word_reader_chk.sv
module sprom_word_reader_chk #(
  parameter int               SEL_W    = 3,
  parameter logic [SEL_W-1:0] SEL_CODE = 3'b101
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic [SEL_W-1:0] dev_sel_o,
  input logic             cs_o,
  input logic             sclk_o,
  input logic             sdo_o,
  input logic             sample_evt,
  input logic             phase_tick
);
  assert_sel_during_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_o |-> dev_sel_o == SEL_CODE);

  assert_sel_before_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) |-> $past(dev_sel_o) == SEL_CODE);

  assert_clk_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> cs_o);

  assert_low_before_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_o) |-> !$past(sclk_o));

  assert_data_set_while_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(sdo_o));

  assert_sample_in_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> (sclk_o && phase_tick));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_lines_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!cs_o && !sclk_o && !sdo_o && dev_sel_o == '0));

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_o && start_i) |=> (cs_o || done_o));
endmodule

bind sprom_word_reader sprom_word_reader_chk #(
  .SEL_W   (SEL_W),
  .SEL_CODE(SEL_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .done_o    (done_o),
  .dev_sel_o (dev_sel_o),
  .cs_o      (cs_o),
  .sclk_o    (sclk_o),
  .sdo_o     (sdo_o),
  .sample_evt(sample_evt),
  .phase_tick(phase_tick)
);

// File: tb/sprom_word_reader_tb_top.sv
module sprom_word_reader_tb_top;
  localparam int D = 3;
  localparam int SW = 3;
  localparam logic [SW-1:0] CODE = 3'b101;
  localparam int FRAME = 55 * D;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [5:0]  addr_i;
  logic        done_o;
  logic [15:0] word_o;
  logic [SW-1:0] dev_sel_o;
  logic        cs_o, sclk_o, sdo_o;
  logic        sdi;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sprom_word_reader #(.HALF_DIV(D), .SEL_W(SW), .SEL_CODE(CODE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .done_o(done_o), .word_o(word_o), .dev_sel_o(dev_sel_o),
    .cs_o(cs_o), .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi)
  );

  function automatic logic [15:0] stub_data(input logic [5:0] a);
    return 16'(int'(a) * 16'h0347 + 16'h81C2);
  endfunction

  function automatic logic [15:0] exchanged(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model (cycle count since accepted start) ---------
  int          c = -1;
  logic [5:0]  m_addr = '0;
  logic [15:0] m_word = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      c = -1;
      m_word = '0;
    end else if (c < 0 || c == FRAME + 1) begin
      if (start_i) begin
        c = 1;
        m_addr = addr_i;
      end else begin
        c = -1;
      end
    end else begin
      c = c + 1;
      if (c == FRAME + 1) m_word = exchanged(stub_data(m_addr));
    end
  end

  function automatic int exp_bit(input int b, input logic [5:0] a);
    logic [3:0] pre;
    pre = 4'b0110;
    if (b < 4)  return int'(pre[3-b]);
    if (b < 10) return int'(a[5-(b-4)]);
    return 0;
  endfunction

  always @(negedge clk) begin
    int e_cs, e_sclk, e_sdo, e_sel, e_done, b, k;
    string sdo_tag;
    e_cs = 0; e_sclk = 0; e_sdo = 0; e_sel = 0; e_done = 0;
    sdo_tag = "R11";
    if (rst_n) begin
      if (c == FRAME + 1) begin
        e_done = 1;
      end else if (c >= 1 && c <= D) begin
        e_sel = int'(CODE);
      end else if (c > D && c <= 2*D) begin
        e_sel = int'(CODE); e_cs = 1;
      end else if (c > 2*D && c <= 54*D) begin
        k = c - 2*D - 1;
        b = k / (2*D);
        e_sel = int'(CODE); e_cs = 1;
        e_sclk = ((k % (2*D)) >= D) ? 1 : 0;
        e_sdo = exp_bit(b, m_addr);
        sdo_tag = (b < 4) ? "R4" : ((b < 10) ? "R5" : "R11");
      end else if (c > 54*D && c <= 55*D) begin
        e_sel = int'(CODE); e_cs = 1;
      end
      chk("R3", "cs_o", int'(cs_o), e_cs);
      chk("R6", "sclk_o", int'(sclk_o), e_sclk);
      chk(sdo_tag, "sdo_o", int'(sdo_o), e_sdo);
      chk("R2", "dev_sel_o", int'(dev_sel_o), e_sel);
      chk("R9", "done_o", int'(done_o), e_done);
      chk("R8", "word_o", int'(word_o), int'(m_word));
    end
  end

  // ---------------- EEPROM stub ------------------------------------------------
  int         rise_n = 0;
  logic [9:0] cap = '0;
  logic       prev_sclk = 1'b0;

  always @(negedge clk) begin
    logic [15:0] dv;
    if (!cs_o) begin
      rise_n = 0;
      sdi = 1'b0;
    end else if (sclk_o && !prev_sclk) begin
      rise_n = rise_n + 1;
      if (rise_n <= 10) begin
        cap = {cap[8:0], sdo_o};
      end else if (rise_n <= 26) begin
        dv = stub_data(cap[5:0]);
        sdi = dv[26 - rise_n];
      end
    end
    prev_sclk = sclk_o;
  end

  // ---------------- watchdog ---------------------------------------------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ---------------------------------------------------
  task automatic wait_done();
    for (int i = 0; i < 4 * FRAME; i++) begin
      @(negedge clk);
      if (done_o) return;
    end
    chk("R9", "done_o never seen", 0, 1);
  endtask

  task automatic post_checks(input logic [5:0] a, input string tag_addr);
    chk("R4", "preamble seen by stub", int'(cap[9:6]), 4'b0110);
    chk(tag_addr, "address seen by stub", int'(cap[5:0]), int'(a));
    chk("R7", "low byte = first received byte", int'(word_o[7:0]), int'(stub_data(a) >> 8));
    chk("R8", "swapped word", int'(word_o), int'(exchanged(stub_data(a))));
  endtask

  task automatic issue(input logic [5:0] a);
    @(negedge clk);
    start_i = 1'b1;
    addr_i  = a;
    @(negedge clk);
    start_i = 1'b0;
    addr_i  = '0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "cs_o in reset", int'(cs_o), 0);
    chk("R1", "sclk_o in reset", int'(sclk_o), 0);
    chk("R1", "sdo_o in reset", int'(sdo_o), 0);
    chk("R1", "dev_sel_o in reset", int'(dev_sel_o), 0);
    chk("R1", "done_o in reset", int'(done_o), 0);
    chk("R1", "word_o in reset", int'(word_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(6'h00); wait_done(); post_checks(6'h00, "R5");
    repeat (4) @(negedge clk);
    issue(6'h3F); wait_done(); post_checks(6'h3F, "R5");
    repeat (4) @(negedge clk);

    // R10: a second strobe mid-frame with a different address
    issue(6'h2A);
    repeat (40) @(negedge clk);
    start_i = 1'b1; addr_i = 6'h15;
    @(negedge clk);
    start_i = 1'b0; addr_i = '0;
    wait_done(); post_checks(6'h2A, "R10");

    // back-to-back: new start in the done cycle
    repeat (3) @(negedge clk);
    issue(6'h15); wait_done(); post_checks(6'h15, "R5");
    start_i = 1'b1; addr_i = 6'h0C;
    @(negedge clk);
    start_i = 1'b0; addr_i = '0;
    wait_done(); post_checks(6'h0C, "R9");

    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule